// File: doc/BRIEF.md
# Converter Sample and Clock-Burst Sequencer

This block sits on the host side of a serial successive-approximation converter and paces its conversions. While enabled it raises a short convert strobe at a programmable rate; the rising edge of that strobe starts a conversion in the converter. The sequencer then holds back the bit clock for a worst-case data-ready time. After that it opens a clock-enable window of exactly the number of bit slots the selected interface needs, so the result can be shifted out. Capturing the shifted data is left to a separate block.

Two serial arrangements are supported. In the forwarded-clock arrangement, the clock goes back to the host alongside the data, and 16 bit clocks are needed. In the header arrangement, a short synchronisation pattern comes before the data, and the burst is 18 clocks long. An older form of the header adds one more leading bit, which makes 19 clocks. All times are given in system-clock cycles. Each conversion latches the pulse width, the ready delay and the burst length at its start.

The sequencer refuses a new convert strobe while a conversion and its burst are still running. When a scheduled sample time arrives during that interval, it records an overrun. The overrun stays recorded until the block is disabled.

Top module: `sar_burst_seq`

## Requirements
- R1: During and just after reset, with enable low, `conv_o`, `bclk_en_o`, `busy_o` and `overrun_o` are all 0.
- R2: Each convert strobe is high for `pulse_cyc_i` consecutive cycles. A value of 0 is treated as 1, and a value above MAX_PULSE_CYC (default 2) is treated as MAX_PULSE_CYC.
- R3: While enabled, sample times come every max(`period_cyc_i`, MIN_PERIOD_CYC) cycles (default minimum 5). The first sample time is the first clock edge at which enable is seen high, so `conv_o` is high in the following cycle.
- R4: The first `bclk_en_o` cycle comes max(`ready_cyc_i`, MIN_READY_CYC) cycles after the first `conv_o` cycle (default minimum 5).
- R5: `bclk_en_o` is high for one unbroken run of cycles per conversion. The run lasts 16 cycles when `hdr_mode_i`=0, 18 when `hdr_mode_i`=1 and `hdr_extra_i`=0, and 19 when both are 1.
- R6: `busy_o` rises together with `conv_o`, stays high through the last `bclk_en_o` cycle and falls in the next cycle.
- R7: A sample time that arrives while `busy_o` is high produces no convert strobe. The next strobe comes at the first later sample time at which the block is idle. Such a refused sample time sets `overrun_o`.
- R8: Once set, `overrun_o` stays high while enable is high. It clears one cycle after enable is sampled low.
- R9: Changing `pulse_cyc_i`, `ready_cyc_i`, `hdr_mode_i` or `hdr_extra_i` after a conversion has started has no effect on that conversion's strobe width, ready delay or burst length.
- R10: Dropping enable during a conversion does not cut that conversion or its burst short, and no further strobe follows.
- R11: `hdr_extra_i` is ignored when `hdr_mode_i`=0, and the burst stays 16 cycles long.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Runs the sample-rate timer; low clears overrun |
| hdr_mode_i | input | 1 | 1 selects the header arrangement, 0 the forwarded-clock arrangement |
| hdr_extra_i | input | 1 | Adds the extra leading header bit (header arrangement only) |
| period_cyc_i | input | CNT_W | Sample period in cycles |
| pulse_cyc_i | input | CNT_W | Convert strobe width in cycles |
| ready_cyc_i | input | CNT_W | Wait from strobe start to first bit clock, in cycles |
| conv_o | output | 1 | Convert strobe |
| bclk_en_o | output | 1 | Bit-clock gate enable |
| busy_o | output | 1 | Conversion or burst in progress |
| overrun_o | output | 1 | Sticky flag: a sample time was refused |

## Verification
The bench builds the block with CNT_W=8, MAX_PULSE_CYC=2, MIN_READY_CYC=5, MIN_PERIOD_CYC=5 and the legacy header bit enabled. With a 20 ns clock, these minimums match a 40 ns strobe ceiling and 100 ns ready and period floors. The 8-bit timing fields keep periods short, so many conversions fit into one run. Periods are drawn just above and just below the busy span. This reaches both the exact boundary at which a busy span equal to the period refuses a sample time and the case where the next strobe skips several periods. Clamping at both ends of the pulse and ready fields is also covered.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

   typedef enum logic [1:0] {
      IFC_FWD     = 2'd0,
      IFC_HDR     = 2'd1,
      IFC_HDR_EXT = 2'd2
   } ifc_e;

   // number of bit-clock slots needed to shift one result out
   function automatic int unsigned burst_slots(input int unsigned data_bits,
                                               input int unsigned hdr_bits,
                                               input ifc_e        ifc);
      int unsigned n;
      case (ifc)
         IFC_HDR:     n = data_bits + hdr_bits;
         IFC_HDR_EXT: n = data_bits + hdr_bits + 1;
         default:     n = data_bits;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/sar_seq_rate.sv
module sar_seq_rate #(
   parameter int unsigned CNT_W          = 12,
   parameter int unsigned MIN_PERIOD_CYC = 5
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             enable_i,
   input  logic [CNT_W-1:0] period_cyc_i,
   output logic             tick_o
);

   localparam logic [CNT_W-1:0] MIN_P = CNT_W'(MIN_PERIOD_CYC);

   logic [CNT_W-1:0] per_eff;
   logic [CNT_W-1:0] cnt_q;

   always_comb begin
      per_eff = (period_cyc_i < MIN_P) ? MIN_P : period_cyc_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (!enable_i) begin
         cnt_q <= '0;
      end else if (cnt_q >= per_eff - 1'b1) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign tick_o = enable_i && (cnt_q == '0);

endmodule

// File: rtl/sar_seq_timer.sv
module sar_seq_timer #(
   parameter int unsigned CNT_W         = 12,
   parameter int unsigned ELAP_W        = 13,
   parameter int unsigned MAX_PULSE_CYC = 2,
   parameter int unsigned MIN_READY_CYC = 5
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic [CNT_W-1:0]  pulse_cyc_i,
   input  logic [CNT_W-1:0]  ready_cyc_i,
   input  logic [ELAP_W-1:0] burst_len_i,
   output logic              conv_o,
   output logic              busy_o,
   output logic [ELAP_W-1:0] elap_o,
   output logic [ELAP_W-1:0] ready_o,
   output logic [ELAP_W-1:0] len_o
);

   localparam logic [CNT_W-1:0] MAX_PW = CNT_W'(MAX_PULSE_CYC);
   localparam logic [CNT_W-1:0] MIN_RD = CNT_W'(MIN_READY_CYC);

   logic [CNT_W-1:0]  pw_eff, rd_eff;
   logic [ELAP_W-1:0] pw_q, rd_q, len_q, elap_q, last_slot;
   logic              conv_q;

   always_comb begin
      if (pulse_cyc_i == '0)       pw_eff = CNT_W'(1);
      else if (pulse_cyc_i > MAX_PW) pw_eff = MAX_PW;
      else                          pw_eff = pulse_cyc_i;
      rd_eff    = (ready_cyc_i < MIN_RD) ? MIN_RD : ready_cyc_i;
      last_slot = rd_q + len_q;
   end

   // elapsed-cycle counter: 1 in the first strobe cycle, 0 when idle
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         elap_q <= '0;
         pw_q   <= '0;
         rd_q   <= '0;
         len_q  <= '0;
      end else if (start_i) begin
         elap_q <= ELAP_W'(1);
         pw_q   <= ELAP_W'(pw_eff);
         rd_q   <= ELAP_W'(rd_eff);
         len_q  <= burst_len_i;
      end else if (elap_q != '0) begin
         if (elap_q == last_slot) elap_q <= '0;
         else                     elap_q <= elap_q + 1'b1;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         conv_q <= 1'b0;
      end else if (start_i) begin
         conv_q <= 1'b1;
      end else if (conv_q && (elap_q == pw_q)) begin
         conv_q <= 1'b0;
      end
   end

   assign conv_o  = conv_q;
   assign busy_o  = (elap_q != '0);
   assign elap_o  = elap_q;
   assign ready_o = rd_q;
   assign len_o   = len_q;

endmodule

// File: rtl/sar_seq_gate.sv
module sar_seq_gate #(
   parameter int unsigned ELAP_W = 13
) (
   input  logic [ELAP_W-1:0] elap_i,
   input  logic [ELAP_W-1:0] ready_i,
   input  logic [ELAP_W-1:0] len_i,
   output logic              gate_o
);

   logic [ELAP_W-1:0] last_slot;

   always_comb begin
      last_slot = ready_i + len_i;
      gate_o    = (elap_i > ready_i) && (elap_i <= last_slot);
   end

endmodule

// File: rtl/sar_burst_seq.sv
module sar_burst_seq #(
   parameter int unsigned CNT_W          = 12,
   parameter int unsigned DATA_BITS      = 16,
   parameter int unsigned HDR_BITS       = 2,
   parameter bit          LEGACY_EN      = 1'b1,
   parameter int unsigned MAX_PULSE_CYC  = 2,
   parameter int unsigned MIN_READY_CYC  = 5,
   parameter int unsigned MIN_PERIOD_CYC = 5
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             enable_i,
   input  logic             hdr_mode_i,
   input  logic             hdr_extra_i,
   input  logic [CNT_W-1:0] period_cyc_i,
   input  logic [CNT_W-1:0] pulse_cyc_i,
   input  logic [CNT_W-1:0] ready_cyc_i,
   output logic             conv_o,
   output logic             bclk_en_o,
   output logic             busy_o,
   output logic             overrun_o
);
   import sar_seq_pkg::*;

   localparam int unsigned ELAP_W   = CNT_W + 1;
   localparam int unsigned MAX_BITS = DATA_BITS + HDR_BITS + 1;

   initial begin
      assert (CNT_W >= 4) else $fatal(1, "CNT_W too small");
      assert (MAX_BITS < (1 << CNT_W)) else $fatal(1, "burst does not fit CNT_W");
      assert (MAX_PULSE_CYC >= 1 && MAX_PULSE_CYC < MIN_READY_CYC)
         else $fatal(1, "strobe must end before the ready time");
      assert (MIN_PERIOD_CYC >= 2 && MIN_PERIOD_CYC < (1 << CNT_W))
         else $fatal(1, "bad minimum period");
      assert (MIN_READY_CYC < (1 << CNT_W)) else $fatal(1, "bad minimum ready");
   end

   ifc_e              ifc;
   logic              tick, start, busy;
   logic [ELAP_W-1:0] burst_len, elap, ready_q, len_q;
   logic              overrun_q;

   always_comb begin
      if (!hdr_mode_i)                   ifc = IFC_FWD;
      else if (hdr_extra_i && LEGACY_EN) ifc = IFC_HDR_EXT;
      else                               ifc = IFC_HDR;
      burst_len = ELAP_W'(burst_slots(DATA_BITS, HDR_BITS, ifc));
   end

   sar_seq_rate #(
      .CNT_W         (CNT_W),
      .MIN_PERIOD_CYC(MIN_PERIOD_CYC)
   ) u_rate (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .enable_i    (enable_i),
      .period_cyc_i(period_cyc_i),
      .tick_o      (tick)
   );

   assign start = tick && !busy;

   sar_seq_timer #(
      .CNT_W        (CNT_W),
      .ELAP_W       (ELAP_W),
      .MAX_PULSE_CYC(MAX_PULSE_CYC),
      .MIN_READY_CYC(MIN_READY_CYC)
   ) u_timer (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .start_i    (start),
      .pulse_cyc_i(pulse_cyc_i),
      .ready_cyc_i(ready_cyc_i),
      .burst_len_i(burst_len),
      .conv_o     (conv_o),
      .busy_o     (busy),
      .elap_o     (elap),
      .ready_o    (ready_q),
      .len_o      (len_q)
   );

   sar_seq_gate #(
      .ELAP_W(ELAP_W)
   ) u_gate (
      .elap_i (elap),
      .ready_i(ready_q),
      .len_i  (len_q),
      .gate_o (bclk_en_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            overrun_q <= 1'b0;
      else if (!enable_i)     overrun_q <= 1'b0;
      else if (tick && busy)  overrun_q <= 1'b1;
   end

   assign busy_o    = busy;
   assign overrun_o = overrun_q;

endmodule

// File: rtl/sar_burst_seq_chk.sv
module sar_burst_seq_chk #(
   parameter int unsigned DATA_BITS     = 16,
   parameter int unsigned HDR_BITS      = 2,
   parameter int unsigned MAX_PULSE_CYC = 2,
   parameter int unsigned MIN_READY_CYC = 5
) (
   input logic clk_i,
   input logic rst_ni,
   input logic enable_i,
   input logic conv_o,
   input logic bclk_en_o,
   input logic busy_o,
   input logic overrun_o
);

   localparam int unsigned MAX_BITS = DATA_BITS + HDR_BITS + 1;

   logic [7:0]  hi_cnt, g_cnt;
   logic [15:0] since_cnt;
   logic        conv_d;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hi_cnt    <= '0;
         g_cnt     <= '0;
         since_cnt <= '0;
         conv_d    <= 1'b0;
      end else begin
         conv_d <= conv_o;
         hi_cnt <= conv_o ? ((hi_cnt == 8'hff) ? hi_cnt : hi_cnt + 1'b1) : '0;
         g_cnt  <= bclk_en_o ? ((g_cnt == 8'hff) ? g_cnt : g_cnt + 1'b1) : '0;
         if (conv_o && !conv_d)        since_cnt <= 16'd1;
         else if (since_cnt != '0 && since_cnt != 16'hffff)
                                       since_cnt <= since_cnt + 1'b1;
      end
   end

   // R2: strobe never stays high longer than the ceiling
   a_r2_pulse_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
      conv_o |-> (32'(hi_cnt) < MAX_PULSE_CYC));

   // R4: bit clocks open only after the ready wait
   a_r4_ready_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(bclk_en_o) |-> (32'(since_cnt) >= MIN_READY_CYC));

   // R5: no burst longer than the longest interface needs
   a_r5_burst_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bclk_en_o |-> (32'(g_cnt) < MAX_BITS));

   // R6: gate lies inside busy, busy ends right after the last slot
   a_r6_gate_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bclk_en_o |-> busy_o);
   a_r6_busy_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(busy_o) |-> $past(bclk_en_o));

   // R7: a strobe starts only from idle
   a_r7_start_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(conv_o) |-> !$past(busy_o));

   // R8: overrun holds while enabled
   a_r8_overrun_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (overrun_o && enable_i) |=> overrun_o);

endmodule

bind sar_burst_seq sar_burst_seq_chk #(
   .DATA_BITS    (DATA_BITS),
   .HDR_BITS     (HDR_BITS),
   .MAX_PULSE_CYC(MAX_PULSE_CYC),
   .MIN_READY_CYC(MIN_READY_CYC)
) u_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .enable_i (enable_i),
   .conv_o   (conv_o),
   .bclk_en_o(bclk_en_o),
   .busy_o   (busy_o),
   .overrun_o(overrun_o)
);

// File: tb/sar_burst_seq_test.sv
module sar_burst_seq_test;

   localparam int CW   = 8;
   localparam int MAXP = 2;
   localparam int MINR = 5;
   localparam int MINP = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          en = 1'b0, hdr = 1'b0, ext = 1'b0;
   logic [CW-1:0] per = 8'd10, pw = 8'd1, rd = 8'd5;
   logic          conv_o, bclk_en_o, busy_o, overrun_o;
   int            cyc_n = 0;
   int            total = 0, bad = 0;

   always #10 clk = ~clk;
   always @(posedge clk) cyc_n <= cyc_n + 1;

   sar_burst_seq #(
      .CNT_W(CW), .DATA_BITS(16), .HDR_BITS(2), .LEGACY_EN(1'b1),
      .MAX_PULSE_CYC(MAXP), .MIN_READY_CYC(MINR), .MIN_PERIOD_CYC(MINP)
   ) uut (
      .clk_i(clk), .rst_ni(rst_n), .enable_i(en),
      .hdr_mode_i(hdr), .hdr_extra_i(ext),
      .period_cyc_i(per), .pulse_cyc_i(pw), .ready_cyc_i(rd),
      .conv_o(conv_o), .bclk_en_o(bclk_en_o), .busy_o(busy_o), .overrun_o(overrun_o)
   );

   function automatic int e_pw(int v);
      return (v == 0) ? 1 : ((v > MAXP) ? MAXP : v);
   endfunction
   function automatic int e_rd(int v);
      return (v < MINR) ? MINR : v;
   endfunction
   function automatic int e_len(bit h, bit x);
      return h ? (x ? 19 : 18) : 16;
   endfunction
   function automatic int e_per(int v);
      return (v < MINP) ? MINP : v;
   endfunction
   function automatic int e_gap(int p, int busy_len);
      return p * (busy_len / p + 1);
   endfunction

   task automatic chk(string what, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   task automatic run_case(int c_pw, int c_rd, bit c_hdr, bit c_ext, int c_per,
                           bit mid, bit drop);
      int cw = 0, gf = -1, gl = 0, bl = 0, k = 0, r1, tmo, ep, eb, nconv;
      bit contig = 1, prev_g = 0;
      ep = e_per(c_per);
      eb = e_rd(c_rd) + e_len(c_hdr, c_ext);
      en = 1'b0;
      tmo = 0;
      @(negedge clk);
      while (busy_o && tmo < 2000) begin @(negedge clk); tmo++; end
      pw = CW'(c_pw); rd = CW'(c_rd); hdr = c_hdr; ext = c_ext; per = CW'(c_per);
      @(negedge clk);
      en = 1'b1;
      tmo = 0;
      @(negedge clk);
      while (!conv_o && tmo < 500) begin @(negedge clk); tmo++; end
      chk("R3 first strobe right after enable", tmo, 0);
      r1 = cyc_n;
      while (1) begin
         if (conv_o) cw++;
         if (bclk_en_o) begin
            if (gf < 0) gf = k;
            else if (!prev_g) contig = 0;
            gl++;
         end
         prev_g = bclk_en_o;
         if (busy_o) bl++;
         if (k == 0) begin
            if (mid) begin   // R9: new settings must not touch this conversion
               pw = CW'(e_pw(c_pw) == 1 ? 2 : 1);
               rd = CW'(e_rd(c_rd) + 7);
               hdr = ~c_hdr; ext = 1'b1;
            end
            if (drop) en = 1'b0;
         end
         k++;
         @(negedge clk);
         if (!busy_o || k > 600) break;
      end
      chk(mid ? "R9 R2 strobe width" : "R2 strobe width", cw, e_pw(c_pw));
      chk(mid ? "R9 R4 ready wait" : "R4 ready wait", gf, e_rd(c_rd));
      chk(mid ? "R9 R5 burst length" : (c_ext && !c_hdr ? "R11 R5 burst length" : "R5 burst length"),
          gl, e_len(c_hdr, c_ext));
      chk("R5 burst unbroken", int'(contig), 1);
      chk("R6 busy span", bl, eb);
      if (drop) begin
         nconv = 0;
         repeat (2 * ep + 5) begin
            if (conv_o || busy_o) nconv++;
            @(negedge clk);
         end
         chk("R10 burst completed then no new strobe", nconv, 0);
      end else begin
         tmo = 0;
         while (!conv_o && tmo < 1000) begin @(negedge clk); tmo++; end
         chk("R3 R7 strobe spacing", cyc_n - r1, e_gap(ep, eb));
         chk("R7 overrun flag", int'(overrun_o), int'(eb >= ep));
         en = 1'b0;
         @(negedge clk);
         @(negedge clk);
         chk("R8 overrun cleared by disable", int'(overrun_o), 0);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      chk("R1 reset conv", int'(conv_o), 0);
      chk("R1 reset busy", int'(busy_o), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 idle outputs", int'({conv_o, bclk_en_o, busy_o, overrun_o}), 0);

      run_case(1, 5, 0, 0, 30, 0, 0);
      run_case(2, 8, 1, 0, 40, 0, 0);
      run_case(2, 5, 1, 1, 40, 0, 0);
      run_case(0, 1, 0, 1, 2, 0, 0);   // clamps, R11, overrun
      run_case(7, 10, 1, 1, 29, 0, 0); // busy span equals period
      run_case(1, 5, 0, 0, 22, 0, 0);  // busy one below period
      run_case(1, 5, 0, 0, 21, 0, 0);  // busy equals period
      run_case(2, 6, 1, 0, 50, 1, 0);  // R9
      run_case(1, 7, 1, 1, 40, 0, 1);  // R10
      for (int i = 0; i < 10; i++) begin
         run_case(int'($urandom_range(0, 3)), int'($urandom_range(0, 12)),
                  1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                  int'($urandom_range(3, 60)), 1'($urandom_range(0, 1)), 0);
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule